// File: doc/BRIEF.md
# Watchdog Timer with Posted Register Writes

This block is a watchdog counter that runs in a slow timer clock domain and is programmed over a plain single-cycle register port in a faster bus clock domain. A 32-bit counter counts upward from a programmable start value, either once per timer clock or once per 2^code timer clocks when the prescaler is on. When it rolls over past all-ones, the block drives a reset pulse for a fixed number of timer clocks and starts again from the start value. Software keeps the system alive by writing a new value to the refresh register before the rollover. Each refresh write restarts the count from the start value.

The counter is started and stopped only by a two-word sequence written to the sequence register. Every write into the timer domain is posted. The write goes across the clock boundary through a toggle handshake, and one pending bit per register stays high until the handshake has returned. A write to a register whose transfer is still pending is dropped. Software polls the pending word before it writes the same register again. The live count comes back to the bus domain through a free-running snapshot handshake.

After reset the counter runs from a default start value, so software must stop it or keep refreshing it. `rst_n` is asynchronous for both domains and is taken to be released cleanly in each of them.

Top module: `wdog_timer`

## Requirements
- R1: A read of word address 0 returns the `REV_ID` parameter in bits 7:0 and zero in all other bits. Writes to addresses 0, 3 and 6 have no effect.
- R2: After reset the counter is running with start value `DEF_LOAD` and the prescaler is off. Reads return 0 from control (address 1), `DEF_LOAD` from start value (address 2), 0 from refresh (address 4) and 0 from pending (address 6). Reset pulses then repeat every 2^32-`DEF_LOAD` timer clocks.
- R3: The counter rolls over from 0xFFFFFFFF while running. At the rollover the reset output goes high for exactly `RST_CYCLES` timer clocks and the counter reloads the start value. The rollover period is (2^32-L)*2^c timer clocks, where L is the start value and c is the prescaler code (c is taken as 0 when the prescaler is off).
- R4: In the control register (address 1), bit 5 turns the prescaler on and bits 4:2 hold the code c. With the prescaler on, the counter advances once every 2^c timer clocks. With it off, the counter advances every timer clock.
- R5: Writing 0x0000BBBB and then 0x00004444 to the sequence register (address 5) starts the counter.
- R6: Writing 0x0000AAAA and then 0x00005555 to the sequence register stops the counter. While stopped, the counter holds its value and no reset pulse occurs.
- R7: After a first sequence word, any word other than its matching second word abandons the sequence. The run state does not change.
- R8: A write to the refresh register (address 4) with a value different from the previous refresh value reloads the counter from the start value. This works whether the counter is running or stopped. Writing the same value again does not reload. The previous refresh value is 0 after reset.
- R9: The pending word (address 6) has one bit per register: bit 0 for control, bit 2 for start value, bit 3 for refresh and bit 4 for sequence. A bit is set in the cycle after its register is written and clears once the transfer has returned to the bus domain.
- R10: A write to a register whose pending bit is set is dropped. Its read-back value and the timer state do not change.
- R11: A read of address 3 returns the live counter value after a short crossing delay.
- R12: A read of control, start value, refresh or sequence returns the last write that was accepted for that register. Control reads back only bits 5:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus clock |
| tclk | input | 1 | Slow timer clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bus_sel | input | 1 | Bus cycle select |
| bus_wr | input | 1 | Write strobe, valid with bus_sel |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| wdt_rst_o | output | 1 | Watchdog reset pulse, timer domain |

## Verification
The assertions assume that the rollover period is longer than `RST_CYCLES`, so a new reset pulse never starts while one is still running. They also assume that one bus write arrives per bus cycle at most, so only one pending bit can rise per cycle. The stimulus uses start values that give periods of 64 timer clocks or more against a four-cycle pulse. It issues each write as a single-cycle strobe and, outside the drop test, waits for the pending word to read zero before the next write to the timer domain.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 3;
  localparam int NUM_CH = 4;
  localparam int PEND_W = 5;
  localparam int CODE_W = 3;
  localparam int PCNT_W = (1 << CODE_W) - 1;

  localparam logic [ADDR_W-1:0] A_REV  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTL  = 3'd1;
  localparam logic [ADDR_W-1:0] A_LOAD = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_TRIG = 3'd4;
  localparam logic [ADDR_W-1:0] A_SEQ  = 3'd5;
  localparam logic [ADDR_W-1:0] A_PEND = 3'd6;

  localparam int CH_CTL  = 0;
  localparam int CH_LOAD = 1;
  localparam int CH_TRIG = 2;
  localparam int CH_SEQ  = 3;

  localparam int CTL_EN_BIT   = 5;
  localparam int CTL_CODE_LSB = 2;

  localparam logic [WORD_W-1:0] SEQ_ON_1  = 32'h0000_BBBB;
  localparam logic [WORD_W-1:0] SEQ_ON_2  = 32'h0000_4444;
  localparam logic [WORD_W-1:0] SEQ_OFF_1 = 32'h0000_AAAA;
  localparam logic [WORD_W-1:0] SEQ_OFF_2 = 32'h0000_5555;

  typedef enum logic [1:0] {SQ_IDLE, SQ_ON_ARMED, SQ_OFF_ARMED} seq_st_e;

  // pending-word layout: bit 1 is a hole, the rest follow channel order
  function automatic logic [PEND_W-1:0] pend_layout(input logic [NUM_CH-1:0] busy);
    return {busy[CH_SEQ], busy[CH_TRIG], busy[CH_LOAD], 1'b0, busy[CH_CTL]};
  endfunction

  // last prescaler count before a counter step for a given code
  function automatic logic [PCNT_W-1:0] prescale_last(input logic [CODE_W-1:0] code);
    return PCNT_W'((1 << code) - 1);
  endfunction

  function automatic logic [WORD_W-1:0] ctl_view(input logic en, input logic [CODE_W-1:0] code);
    logic [WORD_W-1:0] v;
    v = '0;
    v[CTL_EN_BIT] = en;
    v[CTL_CODE_LSB +: CODE_W] = code;
    return v;
  endfunction
endpackage

// File: rtl/wdog_xfer.sv
`timescale 1ns/1ps
// One posted-write channel from the bus domain into the timer domain.
module wdog_xfer #(
  parameter int W    = 32,
  parameter int SYNC = 2
) (
  input  logic         bclk,
  input  logic         tclk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  output logic         busy_o,
  output logic         evt_o,
  output logic [W-1:0] data_o
);
  logic [W-1:0]    hold_q;
  logic            req_q;
  logic [SYNC-1:0] ack_sync;
  logic [SYNC-1:0] req_sync;
  logic            seen_q;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= '0;
      req_q    <= 1'b0;
      ack_sync <= '0;
    end else begin
      ack_sync <= {ack_sync[SYNC-2:0], seen_q};
      if (load_i) begin
        hold_q <= data_i;
        req_q  <= ~req_q;
      end
    end
  end

  always_ff @(posedge tclk or negedge rst_n) begin
    if (!rst_n) begin
      req_sync <= '0;
      seen_q   <= 1'b0;
    end else begin
      req_sync <= {req_sync[SYNC-2:0], req_q};
      seen_q   <= req_sync[SYNC-1];
    end
  end

  assign busy_o = req_q ^ ack_sync[SYNC-1];
  assign evt_o  = req_sync[SYNC-1] ^ seen_q;
  assign data_o = hold_q;
endmodule

// File: rtl/wdog_mirror.sv
`timescale 1ns/1ps
// Free-running snapshot of a timer-domain word into the bus domain.
module wdog_mirror #(
  parameter int W    = 32,
  parameter int SYNC = 2
) (
  input  logic         bclk,
  input  logic         tclk,
  input  logic         rst_n,
  input  logic [W-1:0] value_i,
  output logic [W-1:0] value_o
);
  logic            req_q;
  logic [SYNC-1:0] ack_sync;
  logic [SYNC-1:0] req_sync;
  logic            ack_q;
  logic [W-1:0]    snap_q;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      req_q    <= 1'b0;
      ack_sync <= '0;
      value_o  <= '0;
    end else begin
      ack_sync <= {ack_sync[SYNC-2:0], ack_q};
      if (ack_sync[SYNC-1] == req_q) begin
        value_o <= snap_q;
        req_q   <= ~req_q;
      end
    end
  end

  always_ff @(posedge tclk or negedge rst_n) begin
    if (!rst_n) begin
      req_sync <= '0;
      ack_q    <= 1'b0;
      snap_q   <= '0;
    end else begin
      req_sync <= {req_sync[SYNC-2:0], req_q};
      if (req_sync[SYNC-1] != ack_q) begin
        snap_q <= value_i;
        ack_q  <= req_sync[SYNC-1];
      end
    end
  end
endmodule

// File: rtl/wdog_core.sv
`timescale 1ns/1ps
// Timer-domain counter, prescaler, run sequence and reset pulse.
module wdog_core import wdog_pkg::*; #(
  parameter logic [WORD_W-1:0] DEF_LOAD   = 32'hFFFF_FF00,
  parameter int                RST_CYCLES = 4
) (
  input  logic              tclk,
  input  logic              rst_n,
  input  logic              ctl_evt,
  input  logic [CODE_W:0]   ctl_fld,
  input  logic              load_evt,
  input  logic [WORD_W-1:0] load_word,
  input  logic              trig_evt,
  input  logic [WORD_W-1:0] trig_word,
  input  logic              seq_evt,
  input  logic [WORD_W-1:0] seq_word,
  output logic [WORD_W-1:0] count_o,
  output logic [WORD_W-1:0] load_o,
  output logic              run_o,
  output logic              wrap_o,
  output logic              reload_o,
  output logic              rst_o
);
  localparam int PW = $clog2(RST_CYCLES + 1);

  logic              run_q, pre_en_q;
  logic [CODE_W-1:0] code_q;
  logic [PCNT_W-1:0] pcnt_q;
  logic [WORD_W-1:0] count_q, load_q, trig_last_q, reload_val;
  logic [PW-1:0]     pulse_q;
  seq_st_e           seq_q;
  logic              tick;

  assign tick       = run_q && (!pre_en_q || pcnt_q == prescale_last(code_q));
  assign wrap_o     = tick && (count_q == '1);
  assign reload_o   = trig_evt && (trig_word != trig_last_q);
  assign reload_val = load_evt ? load_word : load_q;

  always_ff @(posedge tclk or negedge rst_n) begin
    if (!rst_n) begin
      run_q       <= 1'b1;
      pre_en_q    <= 1'b0;
      code_q      <= '0;
      pcnt_q      <= '0;
      count_q     <= DEF_LOAD;
      load_q      <= DEF_LOAD;
      trig_last_q <= '0;
      pulse_q     <= '0;
      seq_q       <= SQ_IDLE;
    end else begin
      if (load_evt) load_q <= load_word;
      if (trig_evt) trig_last_q <= trig_word;
      if (ctl_evt) begin
        pre_en_q <= ctl_fld[CODE_W];
        code_q   <= ctl_fld[CODE_W-1:0];
      end
      if (ctl_evt || reload_o || !run_q || !pre_en_q || tick) pcnt_q <= '0;
      else                                                  pcnt_q <= pcnt_q + 1'b1;
      if (reload_o)    count_q <= reload_val;
      else if (wrap_o) count_q <= load_q;
      else if (tick)   count_q <= count_q + 1'b1;
      if (wrap_o)               pulse_q <= PW'(RST_CYCLES);
      else if (pulse_q != '0)   pulse_q <= pulse_q - 1'b1;
      if (seq_evt) begin
        unique case (seq_q)
          SQ_IDLE: begin
            if (seq_word == SEQ_ON_1)       seq_q <= SQ_ON_ARMED;
            else if (seq_word == SEQ_OFF_1) seq_q <= SQ_OFF_ARMED;
          end
          SQ_ON_ARMED: begin
            if (seq_word == SEQ_ON_2) run_q <= 1'b1;
            seq_q <= SQ_IDLE;
          end
          SQ_OFF_ARMED: begin
            if (seq_word == SEQ_OFF_2) run_q <= 1'b0;
            seq_q <= SQ_IDLE;
          end
          default: seq_q <= SQ_IDLE;
        endcase
      end
    end
  end

  assign count_o = count_q;
  assign load_o  = load_q;
  assign run_o   = run_q;
  assign rst_o   = (pulse_q != '0);
endmodule

// File: rtl/wdog_timer.sv
`timescale 1ns/1ps
module wdog_timer import wdog_pkg::*; #(
  parameter logic [WORD_W-1:0] DEF_LOAD   = 32'hFFFF_FF00,
  parameter int                RST_CYCLES = 4,
  parameter logic [7:0]        REV_ID     = 8'h5A,
  parameter int                SYNC       = 2
) (
  input  logic              bclk,
  input  logic              tclk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              wdt_rst_o
);
  logic              wr_req;
  logic [NUM_CH-1:0] ch_hit, ch_take, busy, evt;
  logic [PEND_W-1:0] pend_vec;
  logic [CODE_W:0]   ctl_fld;
  logic [WORD_W-1:0] load_w, trig_w, seq_w, cnt_rd;
  logic              ctl_en_sh;
  logic [CODE_W-1:0] ctl_code_sh;
  logic [WORD_W-1:0] load_sh, trig_sh, seq_sh;
  logic [WORD_W-1:0] core_count, core_load;
  logic              core_run, wrap_evt, reload_evt;

  assign wr_req = bus_sel && bus_wr;

  always_comb begin
    ch_hit          = '0;
    ch_hit[CH_CTL]  = (bus_addr == A_CTL);
    ch_hit[CH_LOAD] = (bus_addr == A_LOAD);
    ch_hit[CH_TRIG] = (bus_addr == A_TRIG);
    ch_hit[CH_SEQ]  = (bus_addr == A_SEQ);
  end
  assign ch_take  = {NUM_CH{wr_req}} & ch_hit & ~busy;
  assign pend_vec = pend_layout(busy);

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en_sh   <= 1'b0;
      ctl_code_sh <= '0;
      load_sh     <= DEF_LOAD;
      trig_sh     <= '0;
      seq_sh      <= '0;
    end else begin
      if (ch_take[CH_CTL]) begin
        ctl_en_sh   <= bus_wdata[CTL_EN_BIT];
        ctl_code_sh <= bus_wdata[CTL_CODE_LSB +: CODE_W];
      end
      if (ch_take[CH_LOAD]) load_sh <= bus_wdata;
      if (ch_take[CH_TRIG]) trig_sh <= bus_wdata;
      if (ch_take[CH_SEQ])  seq_sh  <= bus_wdata;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    if (g == CH_CTL) begin : g_ctl
      wdog_xfer #(.W(CODE_W + 1), .SYNC(SYNC)) u_x (
        .bclk(bclk), .tclk(tclk), .rst_n(rst_n), .load_i(ch_take[g]),
        .data_i(bus_wdata[CTL_EN_BIT:CTL_CODE_LSB]),
        .busy_o(busy[g]), .evt_o(evt[g]), .data_o(ctl_fld));
    end else if (g == CH_LOAD) begin : g_load
      wdog_xfer #(.W(WORD_W), .SYNC(SYNC)) u_x (
        .bclk(bclk), .tclk(tclk), .rst_n(rst_n), .load_i(ch_take[g]),
        .data_i(bus_wdata), .busy_o(busy[g]), .evt_o(evt[g]), .data_o(load_w));
    end else if (g == CH_TRIG) begin : g_trig
      wdog_xfer #(.W(WORD_W), .SYNC(SYNC)) u_x (
        .bclk(bclk), .tclk(tclk), .rst_n(rst_n), .load_i(ch_take[g]),
        .data_i(bus_wdata), .busy_o(busy[g]), .evt_o(evt[g]), .data_o(trig_w));
    end else begin : g_seq
      wdog_xfer #(.W(WORD_W), .SYNC(SYNC)) u_x (
        .bclk(bclk), .tclk(tclk), .rst_n(rst_n), .load_i(ch_take[g]),
        .data_i(bus_wdata), .busy_o(busy[g]), .evt_o(evt[g]), .data_o(seq_w));
    end
  end

  wdog_core #(.DEF_LOAD(DEF_LOAD), .RST_CYCLES(RST_CYCLES)) u_core (
    .tclk(tclk), .rst_n(rst_n),
    .ctl_evt(evt[CH_CTL]), .ctl_fld(ctl_fld),
    .load_evt(evt[CH_LOAD]), .load_word(load_w),
    .trig_evt(evt[CH_TRIG]), .trig_word(trig_w),
    .seq_evt(evt[CH_SEQ]), .seq_word(seq_w),
    .count_o(core_count), .load_o(core_load), .run_o(core_run),
    .wrap_o(wrap_evt), .reload_o(reload_evt), .rst_o(wdt_rst_o));

  wdog_mirror #(.W(WORD_W), .SYNC(SYNC)) u_mirror (
    .bclk(bclk), .tclk(tclk), .rst_n(rst_n),
    .value_i(core_count), .value_o(cnt_rd));

  always_comb begin
    unique case (bus_addr)
      A_REV:   bus_rdata = {{(WORD_W-8){1'b0}}, REV_ID};
      A_CTL:   bus_rdata = ctl_view(ctl_en_sh, ctl_code_sh);
      A_LOAD:  bus_rdata = load_sh;
      A_CNT:   bus_rdata = cnt_rd;
      A_TRIG:  bus_rdata = trig_sh;
      A_SEQ:   bus_rdata = seq_sh;
      A_PEND:  bus_rdata = {{(WORD_W-PEND_W){1'b0}}, pend_vec};
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog_timer_chk.sv
`timescale 1ns/1ps
module wdog_timer_chk #(
  parameter int RST_CYCLES = 4
) (
  input logic        bclk,
  input logic        tclk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic [4:0]  pend_vec,
  input logic [31:0] core_count,
  input logic [31:0] core_load,
  input logic        core_run,
  input logic        wrap_evt,
  input logic        reload_evt,
  input logic        wdt_rst_o
);
  localparam int HW = $clog2(RST_CYCLES + 2) + 1;
  logic [HW-1:0] hi_q;

  always_ff @(posedge tclk or negedge rst_n) begin
    if (!rst_n)                          hi_q <= '0;
    else if (!wdt_rst_o)                 hi_q <= '0;
    else if (hi_q != {HW{1'b1}})         hi_q <= hi_q + 1'b1;
  end

  assert_pend_from_write_R9: assert property (@(posedge bclk) disable iff (!rst_n)
    ((pend_vec & ~$past(pend_vec)) != 5'd0) |-> $past(bus_sel && bus_wr));

  assert_one_pend_rise_R9: assert property (@(posedge bclk) disable iff (!rst_n)
    $onehot0(pend_vec & ~$past(pend_vec)));

  assert_hold_when_stopped_R6: assert property (@(posedge tclk) disable iff (!rst_n)
    (!core_run && !reload_evt) |=> $stable(core_count));

  assert_wrap_reload_R3: assert property (@(posedge tclk) disable iff (!rst_n)
    (wrap_evt && !reload_evt) |=> (core_count == $past(core_load)) && wdt_rst_o);

  assert_single_step_R3: assert property (@(posedge tclk) disable iff (!rst_n)
    (!reload_evt && !wrap_evt) |=>
      (core_count == $past(core_count) || core_count == $past(core_count) + 32'd1));

  assert_pulse_len_R3: assert property (@(posedge tclk) disable iff (!rst_n)
    hi_q <= HW'(RST_CYCLES));

  assert_pulse_from_wrap_R3: assert property (@(posedge tclk) disable iff (!rst_n)
    $rose(wdt_rst_o) |-> $past(wrap_evt));
endmodule

bind wdog_timer wdog_timer_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .bclk(bclk), .tclk(tclk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .pend_vec(pend_vec), .core_count(core_count), .core_load(core_load),
  .core_run(core_run), .wrap_evt(wrap_evt), .reload_evt(reload_evt),
  .wdt_rst_o(wdt_rst_o));

// File: tb/wdog_timer_tb.sv
`timescale 1ns/1ps
module wdog_timer_tb;
  logic        bclk = 1'b0, tclk = 1'b0, rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        wdt_rst;
  int          checks = 0, errors = 0, rises = 0;
  logic        rp = 1'b0;
  bit          done = 1'b0;

  wdog_timer u_dut (.bclk(bclk), .tclk(tclk), .rst_n(rst_n), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .wdt_rst_o(wdt_rst));

  always #10 bclk = ~bclk;
  always #80 tclk = ~tclk;

  always @(negedge tclk) begin
    rp <= wdt_rst;
    if (wdt_rst && !rp) rises <= rises + 1;
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge bclk); bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge bclk); bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge bclk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic tcyc(input int n);
    repeat (n) @(negedge tclk);
  endtask

  task automatic idle();
    logic [31:0] p;
    for (int k = 0; k < 2000; k++) begin
      rd(3'd6, p);
      if (p == 0) break;
    end
  endtask

  task automatic wr_idle(input logic [2:0] a, input logic [31:0] d);
    wr(a, d); idle();
  endtask

  task automatic measure(output int per, output int wid);
    logic pv, first;
    int n;
    pv = wdt_rst; n = 0;
    while (n < 5000) begin
      @(negedge tclk);
      if (wdt_rst && !pv) break;
      pv = wdt_rst; n++;
    end
    wid = 1; per = 0; pv = 1'b1; first = 1'b1;
    while (per < 5000) begin
      @(negedge tclk); per++;
      if (wdt_rst && !pv) break;
      if (!wdt_rst) first = 1'b0;
      if (wdt_rst && first) wid++;
      pv = wdt_rst;
    end
  endtask

  // R1 R2: reset view
  task automatic t_reset();
    logic [31:0] d;
    rd(3'd0, d); chk("R1", "revision", d, 32'h0000_005A);
    rd(3'd1, d); chk("R2", "control after reset", d, 32'h0);
    rd(3'd2, d); chk("R2", "start value after reset", d, 32'hFFFF_FF00);
    rd(3'd4, d); chk("R2", "refresh after reset", d, 32'h0);
    rd(3'd6, d); chk("R2", "pending after reset", d, 32'h0);
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, d); chk("R1", "revision after write", d, 32'h0000_005A);
    rd(3'd6, d); chk("R1", "pending after write to read-only", d, 32'h0);
  endtask

  // R2 R3: default run period and pulse width
  task automatic t_default();
    int p, w;
    measure(p, w);
    chk("R2", "default period", p, 256);
    chk("R3", "pulse width", w, 4);
  endtask

  // R9 R10 R12 R3: pending bit and dropped write
  task automatic t_load();
    logic [31:0] d;
    int p, w;
    wr(3'd2, 32'hFFFF_FFC0);
    rd(3'd6, d); chk("R9", "start-value pending bit", d, 32'h4);
    wr(3'd2, 32'h0000_1234);
    idle();
    rd(3'd2, d); chk("R10", "start value after dropped write", d, 32'hFFFF_FFC0);
    rd(3'd6, d); chk("R9", "pending cleared", d, 32'h0);
    measure(p, w);
    chk("R3", "period with start 0xFFFFFFC0", p, 64);
  endtask

  // R4 R12: prescaler
  task automatic t_prescale();
    logic [31:0] d;
    int p, w;
    wr(3'd1, 32'h0000_0028);
    rd(3'd6, d); chk("R9", "control pending bit", d, 32'h1);
    idle();
    rd(3'd1, d); chk("R12", "control readback", d, 32'h28);
    measure(p, w); chk("R4", "period with code 2", p, 256);
    wr_idle(3'd1, 32'h0000_FFC3);
    rd(3'd1, d); chk("R12", "control keeps bits 5:2 only", d, 32'h0000_0000);
    measure(p, w); chk("R4", "period with prescaler off", p, 64);
  endtask

  // R6 R11: stop
  task automatic t_stop();
    logic [31:0] c1, c2, d;
    int r0;
    wr_idle(3'd5, 32'h0000_AAAA);
    wr_idle(3'd5, 32'h0000_5555);
    rd(3'd5, d); chk("R12", "sequence readback", d, 32'h0000_5555);
    tcyc(20);
    rd(3'd3, c1); r0 = rises;
    tcyc(300);
    rd(3'd3, c2);
    chk("R6", "count held while stopped", c2, c1);
    chk("R6", "no pulse while stopped", rises - r0, 0);
  endtask

  // R7: broken start sequence
  task automatic t_bad_start();
    logic [31:0] c1, c2;
    int r0;
    wr_idle(3'd5, 32'h0000_BBBB);
    wr_idle(3'd5, 32'h0000_1234);
    wr_idle(3'd5, 32'h0000_4444);
    tcyc(10);
    rd(3'd3, c1); r0 = rises;
    tcyc(300);
    rd(3'd3, c2);
    chk("R7", "count held after broken start", c2, c1);
    chk("R7", "no pulse after broken start", rises - r0, 0);
  endtask

  // R8 R11: refresh while stopped, repeated value
  task automatic t_trig_stopped();
    logic [31:0] d;
    wr_idle(3'd2, 32'hFFFF_FFA0);
    wr_idle(3'd4, 32'h0000_0001);
    tcyc(20);
    rd(3'd3, d); chk("R11", "count after refresh", d, 32'hFFFF_FFA0);
    rd(3'd4, d); chk("R12", "refresh readback", d, 32'h1);
    wr_idle(3'd2, 32'hFFFF_FF80);
    wr_idle(3'd4, 32'h0000_0001);
    tcyc(20);
    rd(3'd3, d); chk("R8", "same refresh value ignored", d, 32'hFFFF_FFA0);
  endtask

  // R5 R8: start, then refresh keeps it alive, repeated value does not
  task automatic t_start_refresh();
    int p, w, r0;
    wr_idle(3'd5, 32'h0000_BBBB);
    wr_idle(3'd5, 32'h0000_4444);
    measure(p, w); chk("R5", "period after start", p, 128);
    tcyc(8);
    wr_idle(3'd4, 32'h0000_0002);
    r0 = rises;
    for (int i = 0; i < 12; i++) begin
      wr_idle(3'd4, 32'h2 + (i % 2));
      tcyc(30);
    end
    chk("R8", "no pulse while refreshed", rises - r0, 0);
    r0 = rises;
    for (int i = 0; i < 8; i++) begin
      wr_idle(3'd4, 32'h0000_0003);
      tcyc(30);
    end
    chk("R8", "pulse when refresh value repeats", (rises - r0) > 0, 1);
  endtask

  // R7: broken stop sequence leaves it running
  task automatic t_bad_stop();
    int p, w;
    wr_idle(3'd5, 32'h0000_AAAA);
    wr_idle(3'd5, 32'h0000_0000);
    wr_idle(3'd5, 32'h0000_5555);
    measure(p, w); chk("R7", "still running after broken stop", p, 128);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: run timed out, actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge bclk);
    rst_n = 1'b1;
    t_reset();
    t_default();
    t_load();
    t_prescale();
    t_stop();
    t_bad_start();
    t_trig_stopped();
    t_start_refresh();
    t_bad_stop();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule